// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces one memory address per clock from a small bank of pointer registers and advances the pointer that was used, all in the same cycle. Each access names one of four pointers and one of four step (modify) registers. The pointer's current value goes out on the address port at once. On the next clock edge the pointer moves by the signed step. When the pointer has a nonzero length, the move wraps inside a circular buffer. That buffer starts at the value the pointer held when it was last written, and it spans that many words.

The bank is loaded and read back through a simple register port. A kind field selects pointer, step or length registers, and a slot field picks one of four. The buffer base can be read but cannot be written. Two copies of the block can feed two operand fetches per cycle, because neither needs more than one cycle per address.

Top module: `circ_dag`

## Requirements
- R1: After reset every pointer, step, length and base register reads back as zero.
- R2: While `accValid` is high, `addrOut` equals the selected pointer's value in that same cycle, and `addrValid` equals `accValid`.
- R3: An access without a colliding write sets the selected pointer, at the next clock edge, to its old value plus the selected step, read as a signed 14-bit two's-complement number.
- R4: With length zero the update is plain addition modulo 2^14 (0x3FFE plus 5 gives 0x0003).
- R5: With length L nonzero, an update whose offset from the base reaches L or more is pulled back by L. The base-relative offset is computed modulo 2^14, so a buffer may span address 0x3FFF.
- R6: With length L nonzero, an update whose offset from the base becomes negative is pushed forward by L.
- R7: Writing a pointer also sets its base to the written value. Writing a length or a step, or stepping the pointer, leaves the base unchanged.
- R8: A pointer write and an access to the same pointer in one cycle leave the pointer holding the written value.
- R9: Register kind encoding on `wrKind` and `rdKind` is 0 = pointer, 1 = step, 2 = length, 3 = base. The base is read-only, so a write with kind 3 changes no register.
- R10: An access changes only the selected pointer. The other pointers, all steps and all lengths keep their values.
- R11: Accesses on consecutive cycles each see the pointer value left by the previous access, with no idle cycle needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | Register kind to write (R9 encoding) |
| wrSel | input | 2 | Register slot to write |
| wrData | input | 14 | Write value |
| rdKind | input | 2 | Register kind to read back |
| rdSel | input | 2 | Register slot to read back |
| rdData | output | 14 | Readback value, combinational |
| accValid | input | 1 | Access request |
| accPtr | input | 2 | Pointer used by the access |
| accMod | input | 2 | Step register used by the access |
| addrOut | output | 14 | Address issued for the access |
| addrValid | output | 1 | Address qualifier |

## Verification
A wrong pointer update is not visible in the cycle it happens. It appears at the next access of that pointer, or at the next readback of it, as an address that is off by the step or by one buffer length. The bench therefore compares every issued address and every readback value against a running model, so a bad wrap or a lost collision shows up within one access of that pointer. A base that drifts is invisible until a wrap happens, so the base is also read back directly after length writes and pointer steps.

// File: rtl/circ_dag_pkg.sv
package circ_dag_pkg;

  // Register kind encoding shared by write and readback ports (R9)
  typedef enum logic [1:0] {
    KIND_PTR  = 2'd0,
    KIND_STEP = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_BASE = 2'd3
  } regKind_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic loadStep;
    logic loadLen;
    logic advance;
  } dagStrobe_t;

endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import circ_dag_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             wrEn,
  input  logic [1:0]       wrKind,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             accValid,
  input  logic [SEL_W-1:0] accPtr,
  output dagStrobe_t       strb
);

  logic sameSlot;

  always_comb begin
    sameSlot      = (wrSel == accPtr);
    strb.loadPtr  = wrEn && (wrKind == KIND_PTR);
    strb.loadStep = wrEn && (wrKind == KIND_STEP);
    strb.loadLen  = wrEn && (wrKind == KIND_LEN);
    // a pointer write to the accessed slot takes priority over the step
    strb.advance  = accValid && !(strb.loadPtr && sameSlot);
  end

endmodule

// File: rtl/dag_wrap.sv
module dag_wrap #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);

  localparam int EW = AW + 2;

  logic [AW-1:0]        offset;
  logic signed [EW-1:0] trial;
  logic signed [EW-1:0] lenS;
  logic signed [EW-1:0] fixed;

  always_comb begin
    offset = cur - base;
    trial  = $signed({2'b00, offset}) + $signed({{2{step[AW-1]}}, step});
    lenS   = $signed({2'b00, len});
    fixed  = trial;
    if (trial >= lenS)   fixed = trial - lenS;
    else if (trial < 0)  fixed = trial + lenS;
    if (len == '0) nxt = cur + step;
    else           nxt = base + fixed[AW-1:0];
  end

endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import circ_dag_pkg::*;
#(
  parameter int AW    = 14,
  parameter int NPTR  = 4,
  parameter int NSTEP = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dagStrobe_t       strb,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [AW-1:0]    wrData,
  input  logic [1:0]       rdKind,
  input  logic [SEL_W-1:0] rdSel,
  output logic [AW-1:0]    rdData,
  input  logic [SEL_W-1:0] accPtr,
  input  logic [SEL_W-1:0] accMod,
  output logic [AW-1:0]    curPtr
);

  logic [AW-1:0] ptrQ  [NPTR];
  logic [AW-1:0] baseQ [NPTR];
  logic [AW-1:0] lenQ  [NPTR];
  logic [AW-1:0] stepQ [NSTEP];
  logic [AW-1:0] selStep;
  logic [AW-1:0] nextPtr;

  always_comb begin
    curPtr  = ptrQ[accPtr];
    selStep = stepQ[accMod];
  end

  dag_wrap #(.AW(AW)) u_wrap (
    .cur  (curPtr),
    .base (baseQ[accPtr]),
    .step (selStep),
    .len  (lenQ[accPtr]),
    .nxt  (nextPtr)
  );

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptrQ[p]  <= '0;
        baseQ[p] <= '0;
        lenQ[p]  <= '0;
      end else begin
        if (strb.loadPtr && (wrSel == SEL_W'(p))) begin
          ptrQ[p]  <= wrData;
          baseQ[p] <= wrData;
        end else if (strb.advance && (accPtr == SEL_W'(p))) begin
          ptrQ[p]  <= nextPtr;
        end
        if (strb.loadLen && (wrSel == SEL_W'(p))) lenQ[p] <= wrData;
      end
    end
  end

  for (genvar m = 0; m < NSTEP; m++) begin : g_step
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     stepQ[m] <= '0;
      else if (strb.loadStep && (wrSel == SEL_W'(m))) stepQ[m] <= wrData;
    end
  end

  always_comb begin
    unique case (regKind_t'(rdKind))
      KIND_PTR:  rdData = ptrQ[rdSel];
      KIND_STEP: rdData = stepQ[rdSel];
      KIND_LEN:  rdData = lenQ[rdSel];
      default:   rdData = baseQ[rdSel];
    endcase
  end

endmodule

// File: rtl/circ_dag.sv
module circ_dag
  import circ_dag_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int NUM_PTR = 4,
  parameter int NUM_MOD = 4,
  localparam int SEL_W  = $clog2((NUM_PTR > NUM_MOD) ? NUM_PTR : NUM_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdKind,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ADDR_W-1:0] rdData,
  input  logic              accValid,
  input  logic [SEL_W-1:0]  accPtr,
  input  logic [SEL_W-1:0]  accMod,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid
);

  dagStrobe_t    strb;
  logic [ADDR_W-1:0] curPtr;

  dag_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .wrEn     (wrEn),
    .wrKind   (wrKind),
    .wrSel    (wrSel),
    .accValid (accValid),
    .accPtr   (accPtr),
    .strb     (strb)
  );

  dag_datapath #(
    .AW(ADDR_W), .NPTR(NUM_PTR), .NSTEP(NUM_MOD), .SEL_W(SEL_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .wrSel  (wrSel),
    .wrData (wrData),
    .rdKind (rdKind),
    .rdSel  (rdSel),
    .rdData (rdData),
    .accPtr (accPtr),
    .accMod (accMod),
    .curPtr (curPtr)
  );

  assign addrOut   = curPtr;
  assign addrValid = accValid;

endmodule

// File: rtl/circ_dag_chk.sv
module circ_dag_chk #(
  parameter int ADDR_W = 14,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [1:0]        wrKind,
  input logic [SEL_W-1:0]  wrSel,
  input logic [ADDR_W-1:0] wrData,
  input logic [1:0]        rdKind,
  input logic [SEL_W-1:0]  rdSel,
  input logic [ADDR_W-1:0] rdData,
  input logic              accValid,
  input logic [SEL_W-1:0]  accPtr,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrValid
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rdData == '0));

  // R2
  addr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid == accValid);

  // R2
  addr_matches_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && rdKind == 2'd0 && rdSel == accPtr) |-> (rdData == addrOut));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrKind == 2'd0 && accValid && wrSel == accPtr)
      |=> (rdKind != 2'd0 || rdSel != $past(wrSel) || rdData == $past(wrData)));

  // R7
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdKind == 2'd3 && $past(rdKind) == 2'd3 && rdSel == $past(rdSel)
      && !$past(wrEn && wrKind == 2'd0 && wrSel == rdSel)) |-> $stable(rdData));

endmodule

bind circ_dag circ_dag_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/circ_dag_tb.sv
module circ_dag_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam logic [AW-1:0] MASK = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrKind = '0;
  logic [1:0]    wrSel = '0;
  logic [AW-1:0] wrData = '0;
  logic [1:0]    rdKind = '0;
  logic [1:0]    rdSel = '0;
  logic [AW-1:0] rdData;
  logic          accValid = 1'b0;
  logic [1:0]    accPtr = '0;
  logic [1:0]    accMod = '0;
  logic [AW-1:0] addrOut;
  logic          addrValid;

  int checks = 0;
  int fails = 0;

  logic [AW-1:0] mPtr [4];
  logic [AW-1:0] mBase[4];
  logic [AW-1:0] mLen [4];
  logic [AW-1:0] mStep[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_dag u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrKind(wrKind), .wrSel(wrSel),
    .wrData(wrData), .rdKind(rdKind), .rdSel(rdSel), .rdData(rdData),
    .accValid(accValid), .accPtr(accPtr), .accMod(accMod),
    .addrOut(addrOut), .addrValid(addrValid)
  );

  function automatic logic [AW-1:0] expNext(logic [AW-1:0] cur, logic [AW-1:0] base,
                                            logic [AW-1:0] step, logic [AW-1:0] len);
    int rel;
    int stepS;
    if (len == 0) return cur + step;
    stepS = step[AW-1] ? int'(step) - (1 << AW) : int'(step);
    rel = int'((cur - base) & MASK) + stepS;
    if (rel >= int'(len)) rel -= int'(len);
    else if (rel < 0) rel += int'(len);
    return (base + AW'(rel)) & MASK;
  endfunction

  function automatic logic [AW-1:0] expRead(logic [1:0] k, logic [1:0] s);
    case (k)
      2'd0: return mPtr[s];
      2'd1: return mStep[s];
      2'd2: return mLen[s];
      default: return mBase[s];
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare, update model, wait
  task automatic step(input string req, input bit we, input logic [1:0] wk,
                      input logic [1:0] ws, input logic [AW-1:0] wd,
                      input bit av, input logic [1:0] ap, input logic [1:0] am,
                      input logic [1:0] rk, input logic [1:0] rs);
    logic [AW-1:0] nx;
    wrEn = we; wrKind = wk; wrSel = ws; wrData = wd;
    accValid = av; accPtr = ap; accMod = am; rdKind = rk; rdSel = rs;
    #1;
    check({req, " readback"}, rdData, expRead(rk, rs));
    check({req, " addrValid"}, {{(AW-1){1'b0}}, addrValid}, {{(AW-1){1'b0}}, av});
    if (av) check({req, " address"}, addrOut, mPtr[ap]);
    nx = expNext(mPtr[ap], mBase[ap], mStep[am], mLen[ap]);
    if (av && !(we && wk == 2'd0 && ws == ap)) mPtr[ap] = nx;
    if (we) begin
      case (wk)
        2'd0: begin mPtr[ws] = wd; mBase[ws] = wd; end
        2'd1: mStep[ws] = wd;
        2'd2: mLen[ws] = wd;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(input string req, input logic [1:0] k, input logic [1:0] s, input logic [AW-1:0] d);
    step(req, 1'b1, k, s, d, 1'b0, 2'd0, 2'd0, k, s);
  endtask

  task automatic acc(input string req, input logic [1:0] p, input logic [1:0] m);
    step(req, 1'b0, 2'd0, 2'd0, '0, 1'b1, p, m, 2'd0, p);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 4; i++) begin
      mPtr[i] = '0; mBase[i] = '0; mLen[i] = '0; mStep[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all registers read zero after reset
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        step("R1", 1'b0, 2'd0, 2'd0, '0, 1'b0, 2'd0, 2'd0, 2'(k), 2'(s));

    // R9: base is read-only
    wr("R9", 2'd3, 2'd1, 14'h0155);
    step("R9", 1'b0, 2'd0, 2'd0, '0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd1);
    step("R9", 1'b0, 2'd0, 2'd0, '0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1);

    // R4: linear wrap past the top of the address space
    wr("R4", 2'd0, 2'd0, 14'h3FFE);
    wr("R4", 2'd1, 2'd0, 14'd5);
    acc("R4", 2'd0, 2'd0);
    acc("R4", 2'd0, 2'd0);

    // R5: buffer of 20 spanning 0x3FFF, step 7, back-to-back (R11)
    wr("R5", 2'd0, 2'd1, 14'h3FF0);
    wr("R5", 2'd2, 2'd1, 14'd20);
    wr("R5", 2'd1, 2'd1, 14'd7);
    for (int i = 0; i < 6; i++) acc("R5 R11", 2'd1, 2'd1);

    // R6: buffer of 10 at 0x0100, step -3
    wr("R6", 2'd0, 2'd2, 14'h0100);
    wr("R6", 2'd2, 2'd2, 14'd10);
    wr("R6", 2'd1, 2'd2, 14'h3FFD);
    for (int i = 0; i < 6; i++) acc("R6", 2'd2, 2'd2);

    // R7: base survives stepping and a length write
    wr("R7", 2'd2, 2'd2, 14'd9);
    step("R7", 1'b0, 2'd0, 2'd0, '0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd2);

    // R10: other pointers, steps and lengths untouched by accesses
    for (int s = 0; s < 4; s++) begin
      step("R10", 1'b0, 2'd0, 2'd0, '0, 1'b1, 2'd2, 2'd2, 2'd0, 2'(s));
      step("R10", 1'b0, 2'd0, 2'd0, '0, 1'b1, 2'd1, 2'd1, 2'd1, 2'(s));
      step("R10", 1'b0, 2'd0, 2'd0, '0, 1'b1, 2'd0, 2'd0, 2'd2, 2'(s));
    end

    // R8: write and access to the same pointer in one cycle
    step("R8", 1'b1, 2'd0, 2'd3, 14'h0222, 1'b1, 2'd3, 2'd1, 2'd0, 2'd3);
    step("R8", 1'b0, 2'd0, 2'd0, '0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd3);
    step("R8", 1'b1, 2'd0, 2'd3, 14'h0333, 1'b1, 2'd3, 2'd1, 2'd3, 2'd3);
    acc("R8", 2'd3, 2'd1);

    // random phases; phase 0 linear, later phases circular
    for (int ph = 0; ph < 6; ph++) begin
      for (int p = 0; p < 4; p++) begin
        wr("R3", 2'd2, 2'(p), (ph == 0) ? 14'd0 : AW'(17 + $urandom_range(47)));
        wr("R3", 2'd0, 2'(p), AW'($urandom));
        wr("R3", 2'd1, 2'(p), (ph == 0) ? AW'($urandom) : AW'($urandom_range(32) - 16));
      end
      for (int n = 0; n < 300; n++) begin
        int r;
        logic [AW-1:0] sv;
        r = $urandom_range(99);
        sv = (ph == 0) ? AW'($urandom) : AW'($urandom_range(32) - 16);
        if (r < 8)
          step("R3 R5 R6", 1'b1, 2'd1, 2'($urandom), sv, 1'b1, 2'($urandom), 2'($urandom),
               2'($urandom), 2'($urandom));
        else if (r < 13)
          step("R3 R8", 1'b1, 2'd0, 2'($urandom), AW'($urandom), 1'b1, 2'($urandom),
               2'($urandom), 2'($urandom), 2'($urandom));
        else if (r < 85)
          step((ph == 0) ? "R3 R4 R11" : "R3 R5 R6 R11", 1'b0, 2'd0, 2'd0, '0, 1'b1,
               2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
        else
          step("R10", 1'b0, 2'd0, 2'd0, '0, 1'b0, 2'd0, 2'd0, 2'($urandom), 2'($urandom));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule